// File: doc/BRIEF.md
# Dual-Style Indirect Host Port

This block is the 8-bit parallel side of a data-acquisition device. The host sees only eight locations, selected by a 3-bit address. A pointer location and an auto-incrementing data location give access to an internal register file that is larger than that window. A third location drains a packet FIFO that the acquisition logic fills, and a fourth returns status. The port answers either an Intel-style bus, with separate read and write strobes, or a Motorola-style bus, with one data strobe and a read/write level. A two-bit mode input selects the style.

All host inputs are assumed to be synchronous to `clk`. The port acts on the first clock edge that sees a strobe active, so an access is taken once for each strobe assertion. Read data is registered and held until the next read. `bus_rdy` drops for one clock when the host reads the FIFO while it is empty.

Top module: `dualbus_host_port`

## Requirements
- R1: The port is selected only while both `bus_cs0_n` and `bus_cs1_n` are low. A strobe given while either select is high changes no register or FIFO state, and `bus_dout` keeps its value.
- R2: With `mode_sel` other than 2'b11 (Intel style), a read is taken when `bus_rd_n` goes low and a write when `bus_wr_n` goes low. A strobe held low for several clocks counts as a single access. Read data appears on `bus_dout` one clock after the strobe is first seen low.
- R3: With `mode_sel` = 2'b11 (Motorola style), an access is taken when `bus_wr_n` goes low. `bus_rd_n` gives the direction: 1 reads, 0 writes. `bus_rd_n` going low while `bus_wr_n` stays high does nothing.
- R4: Address 0 is the pointer. It holds PTR_W bits (4 by default). A write keeps the low PTR_W bits of the data, and a read returns the pointer zero-extended.
- R5: Address 1 reads or writes the register-file entry the pointer selects. Each access to address 1, read or write, advances the pointer by one, wrapping modulo 2^PTR_W.
- R6: A read of address 2 pops the packet FIFO in arrival order. A write to address 2 has no effect.
- R7: A read of address 2 while the FIFO is empty returns 0x00. It drives `bus_rdy` low for exactly one clock and sets the underflow flag.
- R8: A read of address 3 returns status: bit 0 is the underflow flag, bit 1 is FIFO empty, bit 2 is FIFO full, bit 7 is 1 in Motorola style, and all other bits are 0. The read returns the flag and then clears it.
- R9: Addresses 4 to 7 read as 0x00. Writes to them change nothing.
- R10: After reset the pointer and all register entries are 0, the FIFO is empty, `bus_dout` is 0x00 and `bus_rdy` is 1.
- R11: `pkt_full` is high while the FIFO holds FIFO_DEPTH entries. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Bus style select; 2'b11 is Motorola style, other values are Intel style |
| bus_cs0_n | input | 1 | First chip select, active low |
| bus_cs1_n | input | 1 | Second chip select, active low |
| bus_rd_n | input | 1 | Read strobe (Intel style) or read/write level (Motorola style) |
| bus_wr_n | input | 1 | Write strobe (Intel style) or data strobe (Motorola style), active low |
| bus_addr | input | 3 | Host location select |
| bus_din | input | 8 | Write data from the host |
| bus_dout | output | 8 | Registered read data to the host |
| bus_rdy | output | 1 | Low for one clock after an empty-FIFO read |
| pkt_push | input | 1 | Push strobe from the packet source |
| pkt_data | input | 8 | Packet byte to push |
| pkt_full | output | 1 | FIFO holds FIFO_DEPTH entries |

## Verification
A pointer that is off by one, or that wraps at the wrong width, returns the wrong register byte on the very next read of address 1. It is also seen directly when address 0 is read back. A wrong FIFO read pointer or count shows at once as bytes out of order, a missing or extra underflow, or a wrong empty or full bit on the next status read. A strobe decode that misses an access, or takes one twice, leaves the pointer or the FIFO one step off. That error is exposed within one further access, so the sweep reads state back after each kind of stimulus, in all four mode settings.

// File: rtl/hbp_pkg.sv
// Shared definitions for the dual-style host port: bus style, host
// location map and status bit positions.
package hbp_pkg;

    typedef enum logic {BUS_INTEL = 1'b0, BUS_MOTO = 1'b1} bus_style_e;

    localparam logic [2:0] LOC_PTR  = 3'd0;
    localparam logic [2:0] LOC_IDX  = 3'd1;
    localparam logic [2:0] LOC_FIFO = 3'd2;
    localparam logic [2:0] LOC_STAT = 3'd3;

    localparam int ST_UNDER = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_FULL  = 2;
    localparam int ST_MOTO  = 7;

    // Map the two mode pins to a bus style; only 2'b11 selects Motorola style.
    function automatic bus_style_e style_of(input logic [1:0] sel);
        return (sel == 2'b11) ? BUS_MOTO : BUS_INTEL;
    endfunction

endpackage

// File: rtl/hbp_strobe_dec.sv
// Turns the host control pins into single-cycle read and write events.
// Assumes the host pins are synchronous to clk. An event fires on the first
// clock that sees the access active, and the "previous" flags reset to
// active so a strobe held through reset is not taken.
module hbp_strobe_dec
    import hbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_style_e style,
    input  logic       cs0_n,
    input  logic       cs1_n,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic       rd_evt,
    output logic       wr_evt
);
    logic sel, rd_act, wr_act, rd_prev, wr_prev;

    // Decide which kind of access the pins describe this cycle.
    always_comb begin
        sel = !cs0_n && !cs1_n;
        if (style == BUS_MOTO) begin
            rd_act = sel && !wr_n && rd_n;
            wr_act = sel && !wr_n && !rd_n;
        end else begin
            rd_act = sel && !rd_n;
            wr_act = sel && !wr_n;
        end
    end

    // Remember last cycle's activity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    // Reads win if both strobes start together.
    assign rd_evt = rd_act && !rd_prev;
    assign wr_evt = wr_act && !wr_prev && !rd_evt;

endmodule

// File: rtl/hbp_regfile.sv
// Indirectly addressed register file with its host-visible pointer.
// Any data access moves the pointer on by one, wrapping at 2^PTR_W.
// Assumes at most one of the three controls is active per cycle.
module hbp_regfile #(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] din,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ENTRIES = 1 << PTR_W;

    logic [DATA_W-1:0] mem [ENTRIES];

    // Pointer load, indexed write and post-increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (ptr_we) begin
            ptr <= din[PTR_W-1:0];
        end else if (data_we) begin
            mem[ptr] <= din;
            ptr      <= ptr + 1'b1;
        end else if (data_re) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign rdata = mem[ptr];

endmodule

// File: rtl/hbp_fifo.sv
// Synchronous packet FIFO. A push while full and a pop while empty are
// ignored. Read data shows the head entry without a pop.
module hbp_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    // Store pushed bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/dualbus_host_port.sv
// 8-bit host port with a three-bit location window. Location 0 is the
// pointer, 1 is indirect register data, 2 is the packet FIFO read port,
// 3 is status, and 4 to 7 read as zero. Read data is registered on the
// clock that takes the read. Assumes host pins are synchronous to clk.
module dualbus_host_port
    import hbp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PTR_W      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              bus_cs0_n,
    input  logic              bus_cs1_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_rdy,
    input  logic              pkt_push,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              pkt_full
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    bus_style_e        style;
    logic              rd_evt, wr_evt;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] reg_rdata, fifo_rdata, rd_mux;
    logic              fifo_empty, fifo_full, fifo_pop, empty_rd;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              underflow_q;

    assign style = style_of(mode_sel);

    hbp_strobe_dec u_dec (
        .clk(clk), .rst_n(rst_n), .style(style),
        .cs0_n(bus_cs0_n), .cs1_n(bus_cs1_n),
        .rd_n(bus_rd_n), .wr_n(bus_wr_n),
        .rd_evt(rd_evt), .wr_evt(wr_evt)
    );

    hbp_regfile #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ptr_we (wr_evt && bus_addr == LOC_PTR),
        .data_we(wr_evt && bus_addr == LOC_IDX),
        .data_re(rd_evt && bus_addr == LOC_IDX),
        .din(bus_din), .ptr(ptr_q), .rdata(reg_rdata)
    );

    assign fifo_pop = rd_evt && bus_addr == LOC_FIFO;
    assign empty_rd = fifo_pop && fifo_empty;

    hbp_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(pkt_push), .wdata(pkt_data), .pop(fifo_pop),
        .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full),
        .count(fifo_cnt)
    );

    assign pkt_full = fifo_full;

    // Select the value a read of the current location returns.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            LOC_PTR:  rd_mux[PTR_W-1:0] = ptr_q;
            LOC_IDX:  rd_mux = reg_rdata;
            LOC_FIFO: rd_mux = fifo_empty ? '0 : fifo_rdata;
            LOC_STAT: begin
                rd_mux[ST_UNDER] = underflow_q;
                rd_mux[ST_EMPTY] = fifo_empty;
                rd_mux[ST_FULL]  = fifo_full;
                rd_mux[ST_MOTO]  = (style == BUS_MOTO);
            end
            default:  rd_mux = '0;
        endcase
    end

    // Register read data and hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_dout <= '0;
        else if (rd_evt) bus_dout <= rd_mux;
    end

    // Drop ready for one clock after an empty-FIFO read.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdy <= 1'b1;
        else        bus_rdy <= !empty_rd;
    end

    // Underflow flag: set by an empty read, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                underflow_q <= 1'b0;
        else if (empty_rd)                         underflow_q <= 1'b1;
        else if (rd_evt && bus_addr == LOC_STAT)   underflow_q <= 1'b0;
    end

endmodule

// File: rtl/hbp_port_chk.sv
// Protocol checks for dualbus_host_port, attached by bind.
module hbp_port_chk #(
    parameter int PTR_W      = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cs0_n,
    input logic             bus_cs1_n,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_dout,
    input logic             bus_rdy,
    input logic             pkt_push,
    input logic             pkt_full,
    input logic             rd_evt,
    input logic             wr_evt,
    input logic             fifo_pop,
    input logic [PTR_W-1:0] ptr,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs0_n || bus_cs1_n) |-> !(rd_evt || wr_evt));

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> $stable(bus_dout));

    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_evt, wr_evt}));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && bus_addr == 3'd1) |=> ptr == PTR_W'($past(ptr) + 1'b1));

    // R7
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdy |=> bus_rdy);

    // R7
    rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdy) |-> $past(rd_evt) && $past(bus_addr) == 3'd2 && bus_dout == 8'h00);

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_full && pkt_push && !fifo_pop) |=> pkt_full && $stable(fifo_cnt));

endmodule

bind dualbus_host_port hbp_port_chk #(
    .PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_rdy(bus_rdy),
    .pkt_push(pkt_push), .pkt_full(pkt_full),
    .rd_evt(rd_evt), .wr_evt(wr_evt), .fifo_pop(fifo_pop),
    .ptr(ptr_q), .fifo_cnt(fifo_cnt)
);

// File: tb/dualbus_host_port_test.sv
// Sweeps all four mode settings across every host location, then covers
// chip select, FIFO fill and hold-strobe cases.
module dualbus_host_port_test;
    localparam int DEPTH = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       cs0 = 1'b1, cs1 = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] din = '0, dout, pkt_data = '0;
    logic       rdy, pkt_push = 1'b0, pkt_full;
    int         n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    dualbus_host_port #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .bus_cs0_n(cs0), .bus_cs1_n(cs1), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_rdy(rdy),
        .pkt_push(pkt_push), .pkt_data(pkt_data), .pkt_full(pkt_full)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One host access; q and r0 sampled one clock after the strobe, r1 a clock later.
    task automatic acc(input logic [2:0] a, input bit is_rd, input logic [7:0] wd,
                       input logic c0, input logic c1,
                       output logic [7:0] q, output logic r0, output logic r1);
        @(negedge clk);
        addr = a; din = wd; cs0 = c0; cs1 = c1;
        if (mode_sel == 2'b11) begin rd_n = is_rd; wr_n = 1'b0; end
        else if (is_rd) rd_n = 1'b0;
        else            wr_n = 1'b0;
        @(negedge clk);
        q = dout; r0 = rdy;
        rd_n = 1'b1; wr_n = 1'b1; cs0 = 1'b1; cs1 = 1'b1;
        @(negedge clk);
        r1 = rdy;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q; logic r0, r1;
        acc(a, 1'b0, d, 1'b0, 1'b0, q, r0, r1);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        logic r0, r1;
        acc(a, 1'b1, 8'h00, 1'b0, 1'b0, q, r0, r1);
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk); pkt_push = 1'b1; pkt_data = v;
        @(negedge clk); pkt_push = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int m);
        return 8'((i * 37 + m * 59 + 5) & 255);
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] q, mb;
        logic r0, r1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 dout after reset", dout, 8'h00);
        chk("R10 rdy after reset", {7'd0, rdy}, 8'h01);
        rd(3'd3, q); chk("R10 status after reset", q, 8'h02);
        rd(3'd0, q); chk("R10 pointer after reset", q, 8'h00);
        rd(3'd1, q); chk("R10 register 0 after reset", q, 8'h00);

        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            mb = (m == 3) ? 8'h80 : 8'h00;
            // R5 fill every entry through the indirect location, then read back
            wr(3'd0, 8'h00);
            for (int i = 0; i < 16; i++) wr(3'd1, pat(i, m));
            rd(3'd0, q); chk("R5 pointer wrapped after writes", q, 8'h00);
            for (int i = 0; i < 16; i++) begin
                rd(3'd1, q); chk("R5 indirect readback", q, pat(i, m));
            end
            rd(3'd0, q); chk("R5 pointer wrapped after reads", q, 8'h00);
            // R4 pointer keeps only its low bits
            wr(3'd0, 8'hF7);
            rd(3'd0, q); chk("R4 pointer masked", q, 8'h07);
            rd(3'd1, q); chk("R5 read at loaded pointer", q, pat(7, m));
            rd(3'd0, q); chk("R5 pointer stepped", q, 8'h08);
            // R6 FIFO order, write to FIFO port ignored
            for (int i = 0; i < 3; i++) push(8'(m * 16 + i + 1));
            rd(3'd3, q); chk("R8 status with data", q, mb);
            wr(3'd2, 8'hEE);
            for (int i = 0; i < 3; i++) begin
                rd(3'd2, q); chk("R6 FIFO order", q, 8'(m * 16 + i + 1));
            end
            // R7 empty read
            acc(3'd2, 1'b1, 8'h00, 1'b0, 1'b0, q, r0, r1);
            chk("R7 empty read data", q, 8'h00);
            chk("R7 rdy low", {7'd0, r0}, 8'h00);
            chk("R7 rdy back high", {7'd0, r1}, 8'h01);
            rd(3'd3, q); chk("R8 status with underflow", q, 8'h03 | mb);
            rd(3'd3, q); chk("R8 underflow cleared", q, 8'h02 | mb);
            // R9 reserved locations
            for (int a = 4; a < 8; a++) begin
                wr(3'(a), 8'hA5);
                rd(3'(a), q); chk("R9 reserved reads zero", q, 8'h00);
            end
            wr(3'd0, 8'h00);
            rd(3'd1, q); chk("R9 registers untouched", q, pat(0, m));
            rd(3'd0, q); chk("R9 pointer untouched", q, 8'h01);
            if (m == 3) begin
                // R3 read level alone without data strobe does nothing
                @(negedge clk); addr = 3'd1; cs0 = 1'b0; cs1 = 1'b0; rd_n = 1'b0;
                repeat (3) @(negedge clk);
                rd_n = 1'b1; cs0 = 1'b1; cs1 = 1'b1;
                rd(3'd0, q); chk("R3 lone level ignored", q, 8'h01);
            end else begin
                // R2 held read strobe counts once
                push(8'h31); push(8'h32);
                @(negedge clk); addr = 3'd2; cs0 = 1'b0; cs1 = 1'b0; rd_n = 1'b0;
                repeat (4) @(negedge clk);
                chk("R2 held strobe data", dout, 8'h31);
                rd_n = 1'b1; cs0 = 1'b1; cs1 = 1'b1;
                rd(3'd2, q); chk("R2 single pop on held strobe", q, 8'h32);
            end
        end

        // R1 chip selects
        mode_sel = 2'b00;
        wr(3'd0, 8'h02);
        acc(3'd0, 1'b0, 8'h09, 1'b1, 1'b0, q, r0, r1);
        acc(3'd0, 1'b0, 8'h09, 1'b0, 1'b1, q, r0, r1);
        acc(3'd0, 1'b0, 8'h09, 1'b1, 1'b1, q, r0, r1);
        rd(3'd0, q); chk("R1 deselected writes ignored", q, 8'h02);
        acc(3'd3, 1'b1, 8'h00, 1'b1, 1'b0, q, r0, r1);
        chk("R1 deselected read holds dout", q, 8'h02);

        // R11 fill past capacity
        for (int i = 0; i < DEPTH + 2; i++) push(8'(8'h40 + i));
        chk("R11 full flag", {7'd0, pkt_full}, 8'h01);
        rd(3'd3, q); chk("R11 status full", q, 8'h04);
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd2, q); chk("R11 retained entries", q, 8'(8'h40 + i));
        end
        acc(3'd2, 1'b1, 8'h00, 1'b0, 1'b0, q, r0, r1);
        chk("R11 extra pushes dropped", {7'd0, r0}, 8'h00);

        summary();
        $finish;
    end
endmodule